// File: doc/BRIEF.md
# Configurable Macrocell Register

This block is the storage element of one programmable logic cell. Static configuration inputs pick how it behaves. It can act as a D, T, JK or SR flip-flop, or as a latch that is transparent while its clock is high. The clock comes from one of two sources, with an optional enable. Asynchronous clear and set come from selectable sources. Output multiplexers choose between the registered value and the combinational sum, select the value that is fed back into the logic array, and drive the output-enable request for the pad.

The block runs on the chip clock `sysClk`. Both cell clock sources, the global clock pin level and a product-term clock, are sampled on that clock. A cell clock edge is a 0-to-1 change between two successive samples. Clear, set and latch transparency act on the outputs in the same cycle. The stored bit takes up the forced value at the next `sysClk` edge.

Top module: `mcell_reg`

## Requirements
- R1: While `rst_n` is low the stored bit is 0. With the registered output selected and no set active, `outVal` reads 0.
- R2: Mode code 0 (D) loads the data input on a rising edge of the selected cell clock and holds it at all other times. The new value shows on `outVal` after the `sysClk` edge that samples the cell clock high.
- R3: Mode code 1 (T) inverts the stored bit on a cell clock edge when the data input is 1, and keeps it when the data input is 0.
- R4: Mode code 2 (JK) takes J from the data input and K from `auxTerm`. On an edge, J=0/K=0 holds, J=0/K=1 gives 0, J=1/K=0 gives 1 and J=1/K=1 inverts.
- R5: Mode code 3 (SR) takes S from the data input and R from `auxTerm`. On an edge, S=1/R=0 gives 1, S=0/R=1 gives 0, and both 0 or both 1 hold.
- R6: Mode code 4 is a latch. While the selected clock level is high the output equals the data input in the same cycle. While that level is low it holds the last value taken while high. The clock enable does not affect this mode. Codes 5 to 7 behave as D.
- R7: `cfgClkSel`=0 selects `gclkPin` as the cell clock and `cfgClkSel`=1 selects `clkTerm`.
- R8: With `cfgClkSel`=0 and `cfgCeUse`=1, a cell clock edge is ignored while `ceTerm` is 0. With `cfgClkSel`=1, `ceTerm` has no effect.
- R9: `cfgRstSel` picks the clear source: 0 none, 1 `gclrN` low, 2 `clkTerm`-independent `rstTerm` high, 3 either of the two. An active clear forces the output to 0 in the same cycle and the stored bit to 0.
- R10: With `cfgPresetUse`=1, `presetTerm` high forces the output and stored bit to 1. A clear active at the same time wins.
- R11: `cfgDataSel`=1 takes the data input from `dataTerm`. `cfgDataSel`=0 takes it from `sumIn` XOR an operand, where `cfgXorSel` 0 gives 0, 1 gives 1, and 2 or 3 gives `xorTerm`.
- R12: `cfgOutReg`=1 drives the register value on both `outVal` and `fbVal`. `cfgOutReg`=0 drives the XOR result on `outVal`. In that case `fbVal` carries the register value when `cfgDataSel`=1 and the XOR result otherwise.
- R13: `cfgOeSel` sets `outEn`: 0 gives 1, 1 gives 0, 2 gives the inverse of `oePinN[0]`, 3 gives the inverse of `oePinN[1]`, 4 gives `oeTerm`, and any other code gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Chip clock that samples all cell inputs |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| cfgMode | input | 3 | Storage mode code |
| cfgClkSel | input | 1 | Cell clock source select |
| cfgCeUse | input | 1 | Use `ceTerm` as clock enable (global clock only) |
| cfgRstSel | input | 2 | Clear source select |
| cfgPresetUse | input | 1 | Enable the set term |
| cfgDataSel | input | 1 | Data from separate term (1) or XOR (0) |
| cfgXorSel | input | 2 | Second XOR operand select |
| cfgOutReg | input | 1 | Registered (1) or combinational (0) output |
| cfgOeSel | input | 3 | Output-enable source select |
| gclkPin | input | 1 | Global clock pin level |
| gclrN | input | 1 | Active-low global clear pin |
| oePinN | input | 2 | Active-low output-enable pins |
| sumIn | input | 1 | OR sum term |
| xorTerm | input | 1 | Product term for the XOR operand |
| dataTerm | input | 1 | Separate data product term |
| auxTerm | input | 1 | K or R input for JK and SR modes |
| clkTerm | input | 1 | Product-term clock |
| ceTerm | input | 1 | Product-term clock enable |
| rstTerm | input | 1 | Product-term clear |
| presetTerm | input | 1 | Product-term set |
| oeTerm | input | 1 | Product-term output enable |
| outVal | output | 1 | Cell output toward the pad |
| fbVal | output | 1 | Feedback into the logic array |
| outEn | output | 1 | Output-enable request for the pad |

## Verification
Random segments hold one configuration for 30 cycles while the clock sources toggle freely and clear and set fire only now and then. In this way each storage mode builds up history, and a wrong next-state rule shows up as a divergent bit. Directed runs then isolate the input pairs that separate the modes: J=K=1 toggles where S=R=1 holds. They also run a blocked clock enable next to the same enable under the term clock, a simultaneous clear and set, and the latch held high against held low, which tells same-cycle transparency from edge capture. Other directed runs put the combinational output with the separate data term next to the registered output, to tell buried feedback from plain feedback. Each output-enable code is applied with opposite pin levels.

// File: rtl/mcell_pkg.sv
`timescale 1ns/1ps
package mcell_pkg;
  typedef enum logic [2:0] {
    MODE_D     = 3'd0,
    MODE_T     = 3'd1,
    MODE_JK    = 3'd2,
    MODE_SR    = 3'd3,
    MODE_LATCH = 3'd4
  } storeMode_e;

  typedef enum logic [1:0] {
    CLR_NONE   = 2'd0,
    CLR_PIN    = 2'd1,
    CLR_TERM   = 2'd2,
    CLR_EITHER = 2'd3
  } clrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;    // qualified cell clock edge, flip-flop modes
    logic pass;    // latch transparent this cycle
    logic clear;   // resolved asynchronous clear
    logic preset;  // resolved asynchronous set
  } cellStrobe_t;
endpackage

// File: rtl/mcell_ctrl.sv
`timescale 1ns/1ps
module mcell_ctrl
  import mcell_pkg::*;
#(
  parameter int OE_PINS = 2
) (
  input  logic                           sysClk,
  input  logic                           rst_n,
  input  logic [2:0]                     cfgMode,
  input  logic                           cfgClkSel,
  input  logic                           cfgCeUse,
  input  logic [1:0]                     cfgRstSel,
  input  logic                           cfgPresetUse,
  input  logic [$clog2(OE_PINS+3)-1:0]   cfgOeSel,
  input  logic                           gclkPin,
  input  logic                           gclrN,
  input  logic [OE_PINS-1:0]             oePinN,
  input  logic                           clkTerm,
  input  logic                           ceTerm,
  input  logic                           rstTerm,
  input  logic                           presetTerm,
  input  logic                           oeTerm,
  output cellStrobe_t                    strobe,
  output logic                           outEn
);
  localparam int TERM_CODE = OE_PINS + 2;

  logic clkLvl;
  logic clkPrev;
  logic ceOk;
  logic isLatch;
  logic clearAct;
  logic [OE_PINS-1:0] pinHit;

  assign clkLvl  = cfgClkSel ? clkTerm : gclkPin;
  assign ceOk    = (!cfgClkSel && cfgCeUse) ? ceTerm : 1'b1;
  assign isLatch = (cfgMode == MODE_LATCH);

  always_ff @(posedge sysClk or negedge rst_n) begin
    if (!rst_n) clkPrev <= 1'b0;
    else        clkPrev <= clkLvl;
  end

  always_comb begin
    case (clrSel_e'(cfgRstSel))
      CLR_PIN:    clearAct = ~gclrN;
      CLR_TERM:   clearAct = rstTerm;
      CLR_EITHER: clearAct = ~gclrN | rstTerm;
      default:    clearAct = 1'b0;
    endcase
  end

  assign strobe.tick   = clkLvl & ~clkPrev & ceOk & ~isLatch;
  assign strobe.pass   = isLatch & clkLvl;
  assign strobe.clear  = clearAct;
  assign strobe.preset = cfgPresetUse & presetTerm;

  // one enable candidate per pin
  for (genvar p = 0; p < OE_PINS; p++) begin : g_oePin
    assign pinHit[p] = (int'(cfgOeSel) == p + 2) & ~oePinN[p];
  end

  always_comb begin
    if (int'(cfgOeSel) == 0)              outEn = 1'b1;
    else if (int'(cfgOeSel) == TERM_CODE) outEn = oeTerm;
    else                                  outEn = |pinHit;
  end
endmodule

// File: rtl/mcell_dpath.sv
`timescale 1ns/1ps
module mcell_dpath
  import mcell_pkg::*;
(
  input  logic        sysClk,
  input  logic        rst_n,
  input  cellStrobe_t strobe,
  input  logic [2:0]  cfgMode,
  input  logic        cfgDataSel,
  input  logic [1:0]  cfgXorSel,
  input  logic        cfgOutReg,
  input  logic        sumIn,
  input  logic        xorTerm,
  input  logic        dataTerm,
  input  logic        auxTerm,
  output logic        outVal,
  output logic        fbVal
);
  logic stateReg;
  logic xorOp;
  logic xorOut;
  logic dIn;
  logic nextFf;
  logic qNow;

  always_comb begin
    case (cfgXorSel)
      2'd0:    xorOp = 1'b0;
      2'd1:    xorOp = 1'b1;
      default: xorOp = xorTerm;
    endcase
  end

  assign xorOut = sumIn ^ xorOp;
  assign dIn    = cfgDataSel ? dataTerm : xorOut;

  always_comb begin
    case (storeMode_e'(cfgMode))
      MODE_T:  nextFf = stateReg ^ dIn;
      MODE_JK: nextFf = (dIn & ~stateReg) | (~auxTerm & stateReg);
      MODE_SR: nextFf = (dIn & auxTerm) ? stateReg : (dIn | (stateReg & ~auxTerm));
      default: nextFf = dIn;
    endcase
  end

  // clear beats set, both beat the latch path
  always_comb begin
    if (strobe.clear)       qNow = 1'b0;
    else if (strobe.preset) qNow = 1'b1;
    else if (strobe.pass)   qNow = dIn;
    else                    qNow = stateReg;
  end

  always_ff @(posedge sysClk or negedge rst_n) begin
    if (!rst_n)           stateReg <= 1'b0;
    else if (strobe.clear || strobe.preset || strobe.pass)
                          stateReg <= qNow;
    else if (strobe.tick) stateReg <= nextFf;
  end

  assign outVal = cfgOutReg ? qNow : xorOut;
  assign fbVal  = (cfgOutReg || cfgDataSel) ? qNow : xorOut;
endmodule

// File: rtl/mcell_reg.sv
`timescale 1ns/1ps
module mcell_reg
  import mcell_pkg::*;
#(
  parameter int OE_PINS = 2
) (
  input  logic                         sysClk,
  input  logic                         rst_n,
  input  logic [2:0]                   cfgMode,
  input  logic                         cfgClkSel,
  input  logic                         cfgCeUse,
  input  logic [1:0]                   cfgRstSel,
  input  logic                         cfgPresetUse,
  input  logic                         cfgDataSel,
  input  logic [1:0]                   cfgXorSel,
  input  logic                         cfgOutReg,
  input  logic [$clog2(OE_PINS+3)-1:0] cfgOeSel,
  input  logic                         gclkPin,
  input  logic                         gclrN,
  input  logic [OE_PINS-1:0]           oePinN,
  input  logic                         sumIn,
  input  logic                         xorTerm,
  input  logic                         dataTerm,
  input  logic                         auxTerm,
  input  logic                         clkTerm,
  input  logic                         ceTerm,
  input  logic                         rstTerm,
  input  logic                         presetTerm,
  input  logic                         oeTerm,
  output logic                         outVal,
  output logic                         fbVal,
  output logic                         outEn
);
  cellStrobe_t strobe;

  mcell_ctrl #(.OE_PINS(OE_PINS)) ctrl_i (
    .sysClk(sysClk), .rst_n(rst_n), .cfgMode(cfgMode), .cfgClkSel(cfgClkSel),
    .cfgCeUse(cfgCeUse), .cfgRstSel(cfgRstSel), .cfgPresetUse(cfgPresetUse),
    .cfgOeSel(cfgOeSel), .gclkPin(gclkPin), .gclrN(gclrN), .oePinN(oePinN),
    .clkTerm(clkTerm), .ceTerm(ceTerm), .rstTerm(rstTerm),
    .presetTerm(presetTerm), .oeTerm(oeTerm), .strobe(strobe), .outEn(outEn)
  );

  mcell_dpath dpath_i (
    .sysClk(sysClk), .rst_n(rst_n), .strobe(strobe), .cfgMode(cfgMode),
    .cfgDataSel(cfgDataSel), .cfgXorSel(cfgXorSel), .cfgOutReg(cfgOutReg),
    .sumIn(sumIn), .xorTerm(xorTerm), .dataTerm(dataTerm), .auxTerm(auxTerm),
    .outVal(outVal), .fbVal(fbVal)
  );
endmodule

// File: rtl/mcell_reg_chk.sv
`timescale 1ns/1ps
module mcell_reg_chk #(
  parameter int OE_PINS = 2
) (
  input logic                         sysClk,
  input logic                         rst_n,
  input logic [2:0]                   cfgMode,
  input logic                         cfgClkSel,
  input logic                         cfgCeUse,
  input logic [1:0]                   cfgRstSel,
  input logic                         cfgPresetUse,
  input logic                         cfgDataSel,
  input logic [1:0]                   cfgXorSel,
  input logic                         cfgOutReg,
  input logic [$clog2(OE_PINS+3)-1:0] cfgOeSel,
  input logic                         sumIn,
  input logic                         dataTerm,
  input logic                         clkTerm,
  input logic                         ceTerm,
  input logic                         rstTerm,
  input logic                         presetTerm,
  input logic                         outVal,
  input logic                         outEn
);
  // term clock level seen last cycle; reads high when term clock was not selected
  logic termSeen;
  always_ff @(posedge sysClk or negedge rst_n) begin
    if (!rst_n) termSeen <= 1'b1;
    else        termSeen <= cfgClkSel ? clkTerm : 1'b1;
  end

  logic plainD, termRise, holdCfg, ceBlocked;
  assign plainD    = (cfgMode == 3'd0) && cfgClkSel && (cfgRstSel == 2'd0) &&
                     !cfgPresetUse && cfgDataSel && cfgOutReg;
  assign termRise  = cfgClkSel && clkTerm && !termSeen;
  assign holdCfg   = !cfgClkSel && (cfgMode != 3'd4) && (cfgRstSel == 2'd0) &&
                     !cfgPresetUse && cfgOutReg;
  assign ceBlocked = holdCfg && cfgCeUse && !ceTerm;

  assert_d_capture_R2: assert property (@(posedge sysClk) disable iff (!rst_n)
    ($past(plainD && termRise) && plainD) |-> (outVal == $past(dataTerm)));

  assert_ce_blocks_R8: assert property (@(posedge sysClk) disable iff (!rst_n)
    ($past(ceBlocked) && holdCfg) |-> $stable(outVal));

  assert_clear_wins_R10: assert property (@(posedge sysClk) disable iff (!rst_n)
    (cfgOutReg && (cfgRstSel == 2'd2) && rstTerm && cfgPresetUse && presetTerm) |-> !outVal);

  assert_comb_sum_R12: assert property (@(posedge sysClk) disable iff (!rst_n)
    (!cfgOutReg && (cfgXorSel == 2'd0)) |-> (outVal == sumIn));

  assert_oe_off_R13: assert property (@(posedge sysClk) disable iff (!rst_n)
    (int'(cfgOeSel) == 1) |-> !outEn);
endmodule

bind mcell_reg mcell_reg_chk #(.OE_PINS(OE_PINS)) chk_i (.*);

// File: tb/mcell_reg_tb_top.sv
`timescale 1ns/1ps
module mcell_reg_tb_top;
  logic sysClk = 1'b0;
  logic rst_n;
  logic [2:0] cfgMode;
  logic cfgClkSel, cfgCeUse, cfgPresetUse, cfgDataSel, cfgOutReg;
  logic [1:0] cfgRstSel, cfgXorSel;
  logic [2:0] cfgOeSel;
  logic gclkPin, gclrN;
  logic [1:0] oePinN;
  logic sumIn, xorTerm, dataTerm, auxTerm, clkTerm, ceTerm, rstTerm, presetTerm, oeTerm;
  logic outVal, fbVal, outEn;

  int vectors = 0;
  int miscomp = 0;
  bit done = 0;
  logic mState, mPrev;

  always #4 sysClk = ~sysClk;

  mcell_reg dut_i (.*);

  task automatic setCfg(input logic [2:0] m, input logic cs, input logic ce,
                        input logic [1:0] rs, input logic pu, input logic ds,
                        input logic [1:0] xs, input logic orr, input logic [2:0] oe);
    cfgMode = m; cfgClkSel = cs; cfgCeUse = ce; cfgRstSel = rs; cfgPresetUse = pu;
    cfgDataSel = ds; cfgXorSel = xs; cfgOutReg = orr; cfgOeSel = oe;
  endtask

  task automatic clearInputs();
    gclkPin = 0; gclrN = 1; oePinN = 2'b11; sumIn = 0; xorTerm = 0; dataTerm = 0;
    auxTerm = 0; clkTerm = 0; ceTerm = 0; rstTerm = 0; presetTerm = 0; oeTerm = 0;
  endtask

  // called just after a falling edge with inputs settled
  task automatic applyAndCheck(input string tag);
    logic clkLvl, ceOk, isLatch, tick, xorOp, xorOut, din, clr, pre, nFf;
    logic qE, outE, fbE, oeE, sNext;
    #2;
    clkLvl  = cfgClkSel ? clkTerm : gclkPin;
    ceOk    = (!cfgClkSel && cfgCeUse) ? ceTerm : 1'b1;
    isLatch = (cfgMode == 3'd4);
    tick    = clkLvl && !mPrev && ceOk && !isLatch;
    xorOp   = (cfgXorSel == 2'd0) ? 1'b0 : (cfgXorSel == 2'd1) ? 1'b1 : xorTerm;
    xorOut  = sumIn ^ xorOp;
    din     = cfgDataSel ? dataTerm : xorOut;
    case (cfgRstSel)
      2'd1: clr = !gclrN;
      2'd2: clr = rstTerm;
      2'd3: clr = !gclrN || rstTerm;
      default: clr = 1'b0;
    endcase
    pre = cfgPresetUse && presetTerm;
    case (cfgMode)
      3'd1: nFf = mState ^ din;
      3'd2: nFf = (din && auxTerm) ? !mState : din ? 1'b1 : auxTerm ? 1'b0 : mState;
      3'd3: nFf = (din && auxTerm) ? mState : din ? 1'b1 : auxTerm ? 1'b0 : mState;
      default: nFf = din;
    endcase
    qE = clr ? 1'b0 : pre ? 1'b1 : (isLatch && clkLvl) ? din : mState;
    sNext = !rst_n ? 1'b0 : (clr || pre || (isLatch && clkLvl)) ? qE : tick ? nFf : mState;
    outE = cfgOutReg ? qE : xorOut;
    fbE  = (cfgOutReg || cfgDataSel) ? qE : xorOut;
    case (cfgOeSel)
      3'd0: oeE = 1'b1;
      3'd2: oeE = !oePinN[0];
      3'd3: oeE = !oePinN[1];
      3'd4: oeE = oeTerm;
      default: oeE = 1'b0;
    endcase
    vectors++;
    if (outVal !== outE || fbVal !== fbE || outEn !== oeE) begin
      miscomp++;
      $display("FAIL %s: out/fb/en actual %b%b%b expected %b%b%b", tag,
               outVal, fbVal, outEn, outE, fbE, oeE);
    end
    @(posedge sysClk);
    mState = sNext;
    mPrev  = rst_n ? clkLvl : 1'b0;
    @(negedge sysClk);
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      miscomp++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  initial begin
    string modeTag [5] = '{"R2 D", "R3 T", "R4 JK", "R5 SR", "R6 latch"};
    void'($urandom(32'd1357));
    rst_n = 0; mState = 0; mPrev = 0;
    clearInputs();
    setCfg(3'd0, 0, 0, 2'd0, 0, 1, 2'd0, 1, 3'd0);
    @(negedge sysClk);
    // R1: edges and data during reset leave the bit at 0
    dataTerm = 1; gclkPin = 1; applyAndCheck("R1 reset hold");
    gclkPin = 0; applyAndCheck("R1 reset hold");
    gclkPin = 1; applyAndCheck("R1 reset hold");
    rst_n = 1; gclkPin = 0; applyAndCheck("R1 after release");

    // R2 / R7: global clock capture, term clock ignored
    clkTerm = 1; applyAndCheck("R7 term clock not selected");
    gclkPin = 1; applyAndCheck("R2 capture edge");
    dataTerm = 0; applyAndCheck("R2 hold while high");
    gclkPin = 0; applyAndCheck("R2 hold while low");

    // R3: T mode
    setCfg(3'd1, 0, 0, 2'd0, 0, 1, 2'd0, 1, 3'd0);
    for (int i = 0; i < 6; i++) begin
      dataTerm = (i < 4); gclkPin = i[0]; applyAndCheck("R3 toggle");
    end

    // R4: JK both high toggles
    setCfg(3'd2, 0, 0, 2'd0, 0, 1, 2'd0, 1, 3'd0);
    dataTerm = 1; auxTerm = 1;
    for (int i = 0; i < 6; i++) begin gclkPin = i[0]; applyAndCheck("R4 J=K=1"); end
    dataTerm = 0; for (int i = 0; i < 2; i++) begin gclkPin = i[0]; applyAndCheck("R4 K only"); end

    // R5: SR both high holds
    setCfg(3'd3, 0, 0, 2'd0, 0, 1, 2'd0, 1, 3'd0);
    dataTerm = 1; auxTerm = 0;
    for (int i = 0; i < 2; i++) begin gclkPin = i[0]; applyAndCheck("R5 set"); end
    auxTerm = 1;
    for (int i = 0; i < 4; i++) begin gclkPin = i[0]; applyAndCheck("R5 S=R=1 hold"); end

    // R8: enable low blocks global edges, ignored with term clock
    setCfg(3'd0, 0, 1, 2'd0, 0, 1, 2'd0, 1, 3'd0);
    auxTerm = 0; ceTerm = 0; dataTerm = 0;
    for (int i = 0; i < 4; i++) begin gclkPin = i[0]; applyAndCheck("R8 enable low"); end
    ceTerm = 1; for (int i = 0; i < 2; i++) begin gclkPin = i[0]; applyAndCheck("R8 enable high"); end
    setCfg(3'd0, 1, 1, 2'd0, 0, 1, 2'd0, 1, 3'd0);
    ceTerm = 0; dataTerm = 1;
    for (int i = 0; i < 4; i++) begin clkTerm = i[0]; applyAndCheck("R8 term clock ignores enable"); end

    // R6: latch transparency
    setCfg(3'd4, 1, 1, 2'd0, 0, 1, 2'd0, 1, 3'd0);
    clkTerm = 1;
    for (int i = 0; i < 4; i++) begin dataTerm = i[0]; applyAndCheck("R6 transparent"); end
    dataTerm = 1; applyAndCheck("R6 transparent");
    clkTerm = 0;
    for (int i = 0; i < 4; i++) begin dataTerm = i[0]; applyAndCheck("R6 held low"); end

    // R9 / R10: clear sources and priority
    setCfg(3'd0, 0, 0, 2'd2, 1, 1, 2'd0, 1, 3'd0);
    presetTerm = 1; applyAndCheck("R10 set");
    rstTerm = 1; applyAndCheck("R10 clear beats set");
    rstTerm = 0; presetTerm = 0; applyAndCheck("R10 after both");
    setCfg(3'd0, 0, 0, 2'd3, 1, 1, 2'd0, 1, 3'd0);
    presetTerm = 1; applyAndCheck("R9 set before pin clear");
    presetTerm = 0; gclrN = 0; applyAndCheck("R9 pin clear in either");
    gclrN = 1; applyAndCheck("R9 cleared");
    setCfg(3'd0, 0, 0, 2'd1, 1, 1, 2'd0, 1, 3'd0);
    presetTerm = 1; applyAndCheck("R9 set");
    presetTerm = 0; rstTerm = 1; applyAndCheck("R9 term ignored on pin select");

    // R12 / R11: buried feedback and combinational output
    setCfg(3'd0, 0, 0, 2'd0, 0, 1, 2'd2, 0, 3'd0);
    rstTerm = 0; sumIn = 1; xorTerm = 1; dataTerm = 0;
    for (int i = 0; i < 4; i++) begin gclkPin = i[0]; applyAndCheck("R12 buried feedback"); end
    cfgDataSel = 0; xorTerm = 0; applyAndCheck("R11 R12 xor feedback");
    cfgXorSel = 2'd1; applyAndCheck("R11 invert");

    // R13: enable codes against pin levels
    for (int s = 0; s < 8; s++) begin
      cfgOeSel = 3'(s);
      oePinN = 2'b10; oeTerm = 1; applyAndCheck("R13 enable select");
      oePinN = 2'b01; oeTerm = 0; applyAndCheck("R13 enable select");
    end

    // random segments
    for (int seg = 0; seg < 100; seg++) begin
      setCfg(3'($urandom % 5), 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
             1'($urandom), 2'($urandom), 1'($urandom), 3'($urandom % 6));
      for (int c = 0; c < 30; c++) begin
        gclkPin = 1'($urandom); clkTerm = 1'($urandom); ceTerm = 1'($urandom);
        sumIn = 1'($urandom); xorTerm = 1'($urandom); dataTerm = 1'($urandom);
        auxTerm = 1'($urandom); oePinN = 2'($urandom); oeTerm = 1'($urandom);
        gclrN = ($urandom % 10) != 0; rstTerm = ($urandom % 10) == 0;
        presetTerm = ($urandom % 10) == 0;
        applyAndCheck($sformatf("%s random seg %0d (R7 R9 R10 R11 R12 R13)",
                                modeTag[cfgMode], seg));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule